// File: doc/BRIEF.md
# Serial EEPROM Target Controller

This block is the on-chip side of an SPI-attached byte memory. A host selects it with an active-low chip select, clocks instruction, address and data bits in on SI, and receives read data and status on SO. The block holds a small byte array, decodes six one-byte instructions, and keeps a write-enable latch that gates every modification. Written bytes collect in a page buffer. The actual programming of the array starts only when chip select is released after a whole-byte write sequence. The program time is a parameterised count of system clocks, and a busy flag is raised for that time.

All serial inputs are sampled by the system clock. SCK edges are found from the synchronised samples. Both idle clock polarities (SPI modes 0 and 3) work without configuration. An active-low pause input can freeze a transfer at any bit. The decoding of the protected address range is left to a neighbouring block. This block presents each address it is about to program, together with its stored 3-bit protection level. The neighbour answers with a single "protected" bit in the same cycle.

Top module: `eeprom_spi_target`

## Requirements
- R1: Instruction 0x06 sets the write-enable latch and 0x04 clears it; the latch is reported in status bit 1 and is 0 after reset.
- R2: Instruction 0x05 returns the status byte on SO and repeats it for as long as chip select stays low; bit 7 is the protect-enable flag, bits 4:2 the protection level, bit 1 the write-enable latch, bit 0 the busy flag, and bits 6:5 read 0. After reset the status byte is 0x00.
- R3: Instruction 0x03 is followed by two address bytes, most significant first, of which only the low ADDR_W bits are used; data leaves on SO MSB first, and the address then increments across the whole array, wrapping from the top address to 0.
- R4: Instruction 0x02 followed by two address bytes and data bytes buffers the data; the array is programmed only when chip select rises with no partial byte pending, and a sequence that ends with a partial byte programs nothing and leaves the write-enable latch set.
- R5: Within one write sequence the address advances in its low PAGE_W bits only, wrapping inside the same 2^PAGE_W-byte page.
- R6: A memory write (0x02) or status write (0x01) received while the write-enable latch is 0 has no effect.
- R7: From the chip-select rise that starts programming, status bit 0 reads 1 for WRITE_CYCLES clocks; in that time every instruction except 0x05 is ignored, and at the end the write-enable latch clears.
- R8: Instruction 0x01 followed by one data byte, with the latch set, loads bit 7 and bits 4:2 of that byte into the status register when its program interval ends; the other bits are dropped.
- R9: During programming the block drives each page address on `protAddr` and its level on `protLevel`; a byte whose address is flagged by `addrProtected` in that cycle is not written.
- R10: Bits are taken on rising SCK and SO changes after falling SCK, whether SCK idles low (mode 0) or high (mode 3).
- R11: While chip select is high `soOe` is 0 and the interface returns to its idle state, so an instruction cut short is discarded and the next one starts at a chip-select fall.
- R12: `holdN` taken low while SCK is low pauses the transfer: `soOe` drops, SCK and SI are ignored, and after `holdN` returns high with SCK low the transfer continues from the same bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, samples all serial pins |
| rstN | input | 1 | Asynchronous active-low reset |
| csN | input | 1 | Active-low chip select |
| sck | input | 1 | Serial clock from the host |
| si | input | 1 | Serial data in |
| holdN | input | 1 | Active-low pause |
| addrProtected | input | 1 | Neighbour's verdict on `protAddr`, same cycle |
| so | output | 1 | Serial data out, valid when `soOe` is 1 |
| soOe | output | 1 | Output enable for SO; 0 means high impedance |
| protAddr | output | ADDR_W | Address being programmed |
| protLevel | output | 3 | Stored protection level |

## Verification
The bench builds the block with a 10-bit array, 64-byte pages and a 3000-clock program interval. With the small array, a read that wraps from the top address to zero, and address bytes whose upper bits must be dropped, fit into short sequences. With the long interval, several status polls and a refused instruction fit inside a single busy window. The bench's own protection model flags the upper half of the array whenever the level is non-zero. This lets one page write show a protected byte that keeps its old contents next to one that changes.

// File: rtl/eeprom_spi_pkg.sv
package eeprom_spi_pkg;

  localparam logic [7:0] OP_SET_WEL = 8'h06;
  localparam logic [7:0] OP_CLR_WEL = 8'h04;
  localparam logic [7:0] OP_RD_STAT = 8'h05;
  localparam logic [7:0] OP_WR_STAT = 8'h01;
  localparam logic [7:0] OP_RD_MEM  = 8'h03;
  localparam logic [7:0] OP_WR_MEM  = 8'h02;

  typedef enum logic [2:0] {
    S_CMD, S_ADDR_HI, S_ADDR_LO, S_RD_DATA,
    S_WR_DATA, S_SR_DATA, S_RDSR, S_IGNORE
  } xferState_e;

  // Strobes from control to datapath, at most one byte event per cycle
  typedef struct packed {
    logic captureHi;
    logic loadRdAddr;
    logic loadWrAddr;
    logic storeByte;
    logic captureSr;
    logic loadStatusTx;
    logic shiftOut;
    logic outStatus;
    logic commitStep;
    logic commitSr;
    logic clearPage;
  } dpStrobe_t;

endpackage

// File: rtl/eeprom_spi_ctrl.sv
module eeprom_spi_ctrl
  import eeprom_spi_pkg::*;
#(
  parameter int PAGE_W       = 6,
  parameter int WRITE_CYCLES = 200
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              csN,
  input  logic              sck,
  input  logic              si,
  input  logic              holdN,
  input  logic              anyValid,
  output dpStrobe_t         strb,
  output logic [7:0]        rxByte,
  output logic [PAGE_W-1:0] commitIdx,
  output logic              wel,
  output logic              busy,
  output logic              soOe
);

  localparam int PAGE_SIZE = 1 << PAGE_W;
  // the interval must cover one clock per page slot
  localparam int TIMER_LEN = (WRITE_CYCLES > PAGE_SIZE) ? WRITE_CYCLES : PAGE_SIZE + 1;
  localparam int CNT_W     = $clog2(TIMER_LEN + 1);

  logic [1:0] csSync, sckSync, siSync, holdSync;
  logic       csS, sckS, siS, holdS;
  logic       csPrev, sckPrev;
  logic       csRise, sckRise, sckFall;
  logic       holdActive, active;

  xferState_e state, nextState;
  logic [2:0] bitCnt;
  logic [6:0] rxSh;
  logic       isWr, isWrNext, srGot;
  logic       byteDone, weSet, weClr, startPage, startSr;

  logic [CNT_W-1:0] cnt;
  logic             commitPage, commitStat, cntLast;

  assign csS   = csSync[1];
  assign sckS  = sckSync[1];
  assign siS   = siSync[1];
  assign holdS = holdSync[1];

  assign csRise  = csS && !csPrev;
  assign sckRise = sckS && !sckPrev;
  assign sckFall = !sckS && sckPrev;
  assign active  = !csS && !holdActive;

  assign rxByte    = {rxSh, siS};
  assign byteDone  = active && sckRise && (bitCnt == 3'd7);
  assign commitIdx = cnt[PAGE_W-1:0];
  assign cntLast   = (cnt == CNT_W'(TIMER_LEN - 1));

  assign startPage = csRise && (state == S_WR_DATA) && (bitCnt == 3'd0) && anyValid;
  assign startSr   = csRise && srGot && (bitCnt == 3'd0);

  assign soOe = !csS && !holdActive && ((state == S_RD_DATA) || (state == S_RDSR));

  always_comb begin
    strb      = '0;
    nextState = state;
    isWrNext  = isWr;
    weSet     = 1'b0;
    weClr     = 1'b0;
    if (byteDone) begin
      case (state)
        S_CMD: begin
          if (busy && (rxByte != OP_RD_STAT)) begin
            nextState = S_IGNORE;
          end else begin
            case (rxByte)
              OP_SET_WEL: begin weSet = 1'b1; nextState = S_IGNORE; end
              OP_CLR_WEL: begin weClr = 1'b1; nextState = S_IGNORE; end
              OP_RD_STAT: begin strb.loadStatusTx = 1'b1; nextState = S_RDSR; end
              OP_WR_STAT: nextState = wel ? S_SR_DATA : S_IGNORE;
              OP_RD_MEM:  begin isWrNext = 1'b0; nextState = S_ADDR_HI; end
              OP_WR_MEM:  begin isWrNext = 1'b1; nextState = wel ? S_ADDR_HI : S_IGNORE; end
              default:    nextState = S_IGNORE;
            endcase
          end
        end
        S_ADDR_HI: begin strb.captureHi = 1'b1; nextState = S_ADDR_LO; end
        S_ADDR_LO: begin
          if (isWr) begin strb.loadWrAddr = 1'b1; nextState = S_WR_DATA; end
          else      begin strb.loadRdAddr = 1'b1; nextState = S_RD_DATA; end
        end
        S_WR_DATA: strb.storeByte = 1'b1;
        S_SR_DATA: begin strb.captureSr = 1'b1; nextState = S_IGNORE; end
        default: ;
      endcase
    end
    if (active && sckFall && ((state == S_RD_DATA) || (state == S_RDSR))) begin
      strb.shiftOut  = 1'b1;
      strb.outStatus = (state == S_RDSR);
    end
    strb.commitStep = busy && commitPage && (cnt < CNT_W'(PAGE_SIZE));
    strb.commitSr   = busy && commitStat && cntLast;
    strb.clearPage  = busy && cntLast;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      csSync     <= 2'b11;
      sckSync    <= 2'b00;
      siSync     <= 2'b00;
      holdSync   <= 2'b11;
      csPrev     <= 1'b1;
      sckPrev    <= 1'b0;
      state      <= S_CMD;
      bitCnt     <= 3'd0;
      rxSh       <= 7'd0;
      isWr       <= 1'b0;
      srGot      <= 1'b0;
      holdActive <= 1'b0;
      wel        <= 1'b0;
      busy       <= 1'b0;
      cnt        <= '0;
      commitPage <= 1'b0;
      commitStat <= 1'b0;
    end else begin
      csSync   <= {csSync[0], csN};
      sckSync  <= {sckSync[0], sck};
      siSync   <= {siSync[0], si};
      holdSync <= {holdSync[0], holdN};
      csPrev   <= csS;
      sckPrev  <= sckS;

      if (csS) begin
        state      <= S_CMD;
        bitCnt     <= 3'd0;
        isWr       <= 1'b0;
        srGot      <= 1'b0;
        holdActive <= 1'b0;
      end else begin
        if (!sckS) holdActive <= !holdS;
        if (active && sckRise) begin
          rxSh   <= rxByte[6:0];
          bitCnt <= bitCnt + 3'd1;
        end
        state <= nextState;
        isWr  <= isWrNext;
        if (byteDone && (state == S_SR_DATA)) srGot <= 1'b1;
      end

      if (weSet) wel <= 1'b1;
      else if (weClr || (busy && cntLast)) wel <= 1'b0;

      if (startPage || startSr) begin
        busy       <= 1'b1;
        cnt        <= '0;
        commitPage <= startPage;
        commitStat <= startSr;
      end else if (busy) begin
        if (cntLast) begin
          busy       <= 1'b0;
          commitPage <= 1'b0;
          commitStat <= 1'b0;
        end else begin
          cnt <= cnt + CNT_W'(1);
        end
      end
    end
  end

endmodule

// File: rtl/eeprom_spi_dp.sv
module eeprom_spi_dp
  import eeprom_spi_pkg::*;
#(
  parameter int ADDR_W = 10,
  parameter int PAGE_W = 6
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpStrobe_t         strb,
  input  logic [7:0]        rxByte,
  input  logic [PAGE_W-1:0] commitIdx,
  input  logic              wel,
  input  logic              busy,
  input  logic              addrProtected,
  output logic              soBit,
  output logic              anyValid,
  output logic [ADDR_W-1:0] protAddr,
  output logic [2:0]        protLevel
);

  localparam int DEPTH     = 1 << ADDR_W;
  localparam int PAGE_SIZE = 1 << PAGE_W;
  localparam int BASE_W    = ADDR_W - PAGE_W;
  localparam int HI_W      = ADDR_W - 8;  // ADDR_W must lie in 9..16

  logic [7:0]        mem     [DEPTH];
  logic [7:0]        pageBuf [PAGE_SIZE];
  logic [PAGE_SIZE-1:0] pageValid;

  logic [HI_W-1:0]   addrHi;
  logic [ADDR_W-1:0] rdAddr, reqAddr, commitAddr;
  logic [BASE_W-1:0] pageBase;
  logic [PAGE_W-1:0] wrOff;
  logic [7:0]        txReg, statusByte;
  logic [2:0]        txCnt;
  logic [2:0]        bpReg, srPendBp;
  logic              wpenReg, srPendWpen, writeCell;

  assign reqAddr    = {addrHi, rxByte};
  assign commitAddr = {pageBase, commitIdx};
  assign statusByte = {wpenReg, 2'b00, bpReg, wel, busy};
  assign writeCell  = strb.commitStep && pageValid[commitIdx] && !addrProtected;
  assign anyValid   = |pageValid;
  assign protAddr   = commitAddr;
  assign protLevel  = bpReg;

  always_ff @(posedge clk) begin
    if (writeCell)      mem[commitAddr] <= pageBuf[commitIdx];
    if (strb.storeByte) pageBuf[wrOff]  <= rxByte;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      addrHi     <= '0;
      rdAddr     <= '0;
      pageBase   <= '0;
      wrOff      <= '0;
      pageValid  <= '0;
      txReg      <= 8'd0;
      txCnt      <= 3'd0;
      soBit      <= 1'b0;
      bpReg      <= 3'd0;
      wpenReg    <= 1'b0;
      srPendBp   <= 3'd0;
      srPendWpen <= 1'b0;
    end else begin
      if (strb.captureHi) addrHi <= rxByte[HI_W-1:0];
      if (strb.loadRdAddr) begin
        txReg  <= mem[reqAddr];
        rdAddr <= reqAddr + ADDR_W'(1);
        txCnt  <= 3'd0;
      end
      if (strb.loadStatusTx) begin
        txReg <= statusByte;
        txCnt <= 3'd0;
      end
      if (strb.shiftOut) begin
        soBit <= txReg[7];
        txCnt <= txCnt + 3'd1;
        if (txCnt == 3'd7) begin
          if (strb.outStatus) begin
            txReg <= statusByte;
          end else begin
            txReg  <= mem[rdAddr];
            rdAddr <= rdAddr + ADDR_W'(1);
          end
        end else begin
          txReg <= {txReg[6:0], 1'b0};
        end
      end
      if (strb.loadWrAddr) begin
        pageBase  <= reqAddr[ADDR_W-1:PAGE_W];
        wrOff     <= reqAddr[PAGE_W-1:0];
        pageValid <= '0;
      end
      if (strb.storeByte) begin
        pageValid[wrOff] <= 1'b1;
        wrOff            <= wrOff + PAGE_W'(1);
      end
      if (strb.clearPage) pageValid <= '0;
      if (strb.captureSr) begin
        srPendWpen <= rxByte[7];
        srPendBp   <= rxByte[4:2];
      end
      if (strb.commitSr) begin
        wpenReg <= srPendWpen;
        bpReg   <= srPendBp;
      end
    end
  end

endmodule

// File: rtl/eeprom_spi_target.sv
module eeprom_spi_target
  import eeprom_spi_pkg::*;
#(
  parameter int ADDR_W       = 10,
  parameter int PAGE_W       = 6,
  parameter int WRITE_CYCLES = 200
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              csN,
  input  logic              sck,
  input  logic              si,
  input  logic              holdN,
  input  logic              addrProtected,
  output logic              so,
  output logic              soOe,
  output logic [ADDR_W-1:0] protAddr,
  output logic [2:0]        protLevel
);

  dpStrobe_t         strb;
  logic [7:0]        rxByte;
  logic [PAGE_W-1:0] commitIdx;
  logic              wel, busy, anyValid;

  eeprom_spi_ctrl #(
    .PAGE_W(PAGE_W), .WRITE_CYCLES(WRITE_CYCLES)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .csN(csN), .sck(sck), .si(si), .holdN(holdN),
    .anyValid(anyValid), .strb(strb), .rxByte(rxByte), .commitIdx(commitIdx),
    .wel(wel), .busy(busy), .soOe(soOe)
  );

  eeprom_spi_dp #(
    .ADDR_W(ADDR_W), .PAGE_W(PAGE_W)
  ) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .rxByte(rxByte), .commitIdx(commitIdx),
    .wel(wel), .busy(busy), .addrProtected(addrProtected), .soBit(so),
    .anyValid(anyValid), .protAddr(protAddr), .protLevel(protLevel)
  );

endmodule

// File: rtl/eeprom_spi_target_chk.sv
module eeprom_spi_target_chk (
  input logic       clk,
  input logic       rstN,
  input logic       csN,
  input logic       soOe,
  input logic       busy,
  input logic       wel,
  input logic       commitStep,
  input logic [2:0] protLevel
);

  // R11
  so_only_selected_chk: assert property (@(posedge clk) disable iff (!rstN)
    soOe |-> !$past(csN, 2));

  // R7
  wel_cleared_after_cycle_chk: assert property (@(posedge clk) disable iff (!rstN)
    $fell(busy) |-> !wel);

  // R7
  wel_not_set_while_busy_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(wel) |-> !$past(busy));

  // R4
  array_write_only_busy_chk: assert property (@(posedge clk) disable iff (!rstN)
    commitStep |-> busy);

  // R8
  level_moves_at_cycle_end_chk: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(protLevel) |-> $fell(busy));

endmodule

bind eeprom_spi_target eeprom_spi_target_chk u_chk (
  .clk(clk), .rstN(rstN), .csN(csN), .soOe(soOe), .busy(busy), .wel(wel),
  .commitStep(strb.commitStep), .protLevel(protLevel)
);

// File: tb/tb_eeprom_spi_target.sv
module tb_eeprom_spi_target;

  localparam int CLK_PERIOD = 10;
  localparam int HALF       = 8;
  localparam int ADDR_W     = 10;
  localparam int PAGE_W     = 6;
  localparam int WCYC       = 3000;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic csN = 1'b1, sck = 1'b0, si = 1'b0, holdN = 1'b1;
  logic so, soOe, addrProtected;
  logic [ADDR_W-1:0] protAddr;
  logic [2:0] protLevel;

  int nTests = 0, nFail = 0;
  bit mode3 = 1'b0;
  logic [7:0] wbuf [8];
  logic [7:0] rbuf [8];
  logic [7:0] st;

  always #(CLK_PERIOD/2) clk = ~clk;

  // bench protection model: upper half protected when level is non-zero
  assign addrProtected = (protLevel != 3'd0) && protAddr[ADDR_W-1];

  eeprom_spi_target #(.ADDR_W(ADDR_W), .PAGE_W(PAGE_W), .WRITE_CYCLES(WCYC)) dut (
    .clk(clk), .rstN(rstN), .csN(csN), .sck(sck), .si(si), .holdN(holdN),
    .addrProtected(addrProtected), .so(so), .soOe(soOe),
    .protAddr(protAddr), .protLevel(protLevel)
  );

  typedef struct packed {
    logic        m3;
    logic [15:0] wa;
    logic [15:0] ra;
    logic [7:0]  d;
  } vec_t;

  localparam vec_t VECS [7] = '{
    '{1'b0, 16'h0000, 16'h0000, 8'h77},
    '{1'b1, 16'h0010, 16'h0010, 8'hA5},
    '{1'b0, 16'h0123, 16'h0123, 8'h3C},
    '{1'b1, 16'h03FF, 16'h03FF, 8'h81},
    '{1'b0, 16'hFC40, 16'h0040, 8'h5A},
    '{1'b1, 16'h0301, 16'h0301, 8'hFF},
    '{1'b0, 16'h0200, 16'h8200, 8'h00}
  };

  task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
    nTests++;
    if (got !== exp) begin
      nFail++;
      $display("FAIL %s got %0h expected %0h", tag, got, exp);
    end
  endtask

  task automatic waitClk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic doHold();
    holdN = 1'b0;
    waitClk(6);
    check("R12 soOe during pause", soOe, 1'b0);
    for (int k = 0; k < 2; k++) begin
      sck = 1'b1; si = ~si; waitClk(4);
      sck = 1'b0; waitClk(4);
    end
    holdN = 1'b1;
    waitClk(6);
  endtask

  task automatic xferBits(input logic [7:0] tx, input int nbits, input int holdAt,
                          output logic [7:0] rx);
    rx = 8'h00;
    for (int i = 7; i > 7 - nbits; i--) begin
      if (holdAt == i) doHold();
      if (mode3) sck = 1'b0;
      si = tx[i];
      waitClk(HALF);
      rx[i] = soOe ? so : 1'bx;
      sck = 1'b1;
      waitClk(HALF);
      if (!mode3) sck = 1'b0;
    end
  endtask

  task automatic csLow();
    sck = mode3;
    waitClk(2);
    csN = 1'b0;
    waitClk(HALF);
  endtask

  task automatic csHigh();
    waitClk(HALF);
    csN = 1'b1;
    waitClk(20);
  endtask

  task automatic cmd1(input logic [7:0] op);
    logic [7:0] r;
    csLow(); xferBits(op, 8, -1, r); csHigh();
  endtask

  task automatic rdsr(output logic [7:0] s);
    logic [7:0] r;
    csLow(); xferBits(8'h05, 8, -1, r); xferBits(8'h00, 8, -1, s); csHigh();
  endtask

  task automatic wrsr(input logic [7:0] v);
    logic [7:0] r;
    csLow(); xferBits(8'h01, 8, -1, r); xferBits(v, 8, -1, r); csHigh();
  endtask

  task automatic writeMem(input logic [15:0] a, input int n, input int partial);
    logic [7:0] r;
    csLow();
    xferBits(8'h02, 8, -1, r);
    xferBits(a[15:8], 8, -1, r);
    xferBits(a[7:0], 8, -1, r);
    for (int k = 0; k < n; k++) xferBits(wbuf[k], 8, -1, r);
    if (partial > 0) xferBits(8'h99, partial, -1, r);
    csHigh();
  endtask

  task automatic readMem(input logic [15:0] a, input int n, input int holdAt);
    logic [7:0] r;
    csLow();
    xferBits(8'h03, 8, -1, r);
    xferBits(a[15:8], 8, -1, r);
    xferBits(a[7:0], 8, -1, r);
    for (int k = 0; k < n; k++) xferBits(8'h00, 8, (k == 0) ? holdAt : -1, rbuf[k]);
    csHigh();
  endtask

  task automatic waitReady();
    logic [7:0] s;
    for (int k = 0; k < 40; k++) begin
      rdsr(s);
      if (s[0] == 1'b0) break;
    end
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    nFail++;
    $display("FAIL watchdog (all requirements) got timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", nTests, nFail);
    $finish;
  end

  initial begin
    logic [7:0] r, s0, s1;
    waitClk(5);
    rstN = 1'b1;
    waitClk(5);

    // reset state
    check("R11 soOe with cs high", soOe, 1'b0);
    rdsr(st);
    check("R2 status after reset", st, 8'h00);

    // R1 latch set / clear
    cmd1(8'h06); rdsr(st); check("R1 WREN sets latch", st, 8'h02);
    // R2 status repeats while selected
    csLow(); xferBits(8'h05, 8, -1, r); xferBits(8'h00, 8, -1, s0); xferBits(8'h00, 8, -1, s1); csHigh();
    check("R2 status byte 1", s0, 8'h02);
    check("R2 status byte 2", s1, 8'h02);
    cmd1(8'h04); rdsr(st); check("R1 WRDI clears latch", st, 8'h00);

    // vector table: write one byte, wait, read back (R3 R4 R10)
    foreach (VECS[i]) begin
      mode3 = VECS[i].m3;
      cmd1(8'h06);
      wbuf[0] = VECS[i].d;
      writeMem(VECS[i].wa, 1, 0);
      waitReady();
      readMem(VECS[i].ra, 1, -1);
      check($sformatf("R4 R10 vector %0d readback", i), rbuf[0], VECS[i].d);
    end
    mode3 = 1'b0;

    // R6 write and status write without latch
    wbuf[0] = 8'h11;
    writeMem(16'h0010, 1, 0);
    rdsr(st); check("R6 no busy after refused write", st, 8'h00);
    readMem(16'h0010, 1, -1); check("R6 data unchanged", rbuf[0], 8'hA5);
    wrsr(8'h9C);
    waitClk(WCYC + 50);
    rdsr(st); check("R6 status write refused", st, 8'h00);

    // R5 page wrap, R7 busy behaviour
    cmd1(8'h06);
    wbuf[0] = 8'hD0; wbuf[1] = 8'hD1; wbuf[2] = 8'hD2; wbuf[3] = 8'hD3;
    writeMem(16'h00BE, 4, 0);
    rdsr(st); check("R7 busy and latch during cycle", st, 8'h03);
    cmd1(8'h04);
    rdsr(st); check("R7 WRDI ignored while busy", st, 8'h03);
    waitReady();
    rdsr(st); check("R7 latch cleared after cycle", st, 8'h00);
    readMem(16'h00BE, 2, -1);
    check("R5 byte at 0xBE", rbuf[0], 8'hD0);
    check("R5 byte at 0xBF", rbuf[1], 8'hD1);
    readMem(16'h0080, 2, -1);
    check("R5 wrapped byte at 0x80", rbuf[0], 8'hD2);
    check("R5 wrapped byte at 0x81", rbuf[1], 8'hD3);

    // R3 sequential read rolls over from top to 0
    readMem(16'h03FF, 2, -1);
    check("R3 top byte", rbuf[0], 8'h81);
    check("R3 rollover to 0", rbuf[1], 8'h77);

    // R8 status write, R9 protection
    cmd1(8'h06); wrsr(8'hFF); waitReady();
    rdsr(st); check("R8 status after write", st, 8'h9C);
    check("R9 level output", protLevel, 3'b111);
    cmd1(8'h06); wbuf[0] = 8'h12; writeMem(16'h0301, 1, 0); waitReady();
    readMem(16'h0301, 1, -1); check("R9 protected byte kept", rbuf[0], 8'hFF);
    cmd1(8'h06); wbuf[0] = 8'h34; writeMem(16'h0011, 1, 0); waitReady();
    readMem(16'h0011, 1, -1); check("R9 unprotected byte written", rbuf[0], 8'h34);
    cmd1(8'h06); wrsr(8'h00); waitReady();
    rdsr(st); check("R8 status cleared", st, 8'h00);

    // R4 partial trailing byte cancels the write
    cmd1(8'h06); wbuf[0] = 8'h99; writeMem(16'h0011, 1, 5);
    rdsr(st); check("R4 partial byte: no cycle, latch kept", st, 8'h02);
    readMem(16'h0011, 1, -1); check("R4 partial byte: data kept", rbuf[0], 8'h34);
    cmd1(8'h04);

    // R12 pause in the middle of a read
    readMem(16'h0010, 2, 4);
    check("R12 first byte across pause", rbuf[0], 8'hA5);
    check("R12 second byte after pause", rbuf[1], 8'h34);

    // R11 truncated instruction discarded
    csLow(); xferBits(8'h03, 4, -1, r); csHigh();
    rdsr(st); check("R11 fresh command after abort", st, 8'h00);
    check("R11 soOe idle", soOe, 1'b0);

    $display("[TB] %0d tests run, %0d failed", nTests, nFail);
    $finish;
  end

endmodule